// File: doc/BRIEF.md
# Command-Code Wiper Register Target

This block is a serial-bus target that holds one 7-bit wiper setting. A controller reaches it through a fixed 7-bit bus address. Every access then carries a one-byte command code, and only the value 00h selects the wiper. After a valid command, a write stores the low seven bits of each data byte that follows. A read, started with a repeated Start and the address with the read bit set, returns the current setting with a zero in the top bit. The read keeps returning that byte for as long as the controller acknowledges.

The raw clock and data lines are oversampled by the system clock. Each line passes through a two-stage synchroniser and then a counter filter that rejects pulses shorter than a configurable width. The block pulls the data line low through an active-low output enable. It changes that enable only after a hold delay counted from the falling clock edge. Reset and an active brown-out input both force the setting to mid-scale, 40h. While brown-out is active, the bus side stays silent.

Top module: `wiper_reg_i2c_target`

## Requirements
- R1: The target acknowledges only its own address, 0101110 by default or 0111110 when ALT_ADDR is set, plus the general-call address 00h with the write bit. Any other address is left unacknowledged and the data line is never pulled.
- R2: A write of address+W, command 00h and one data byte acknowledges all three bytes. The wiper output then takes data bits 6:0, and bit 7 of the data byte has no effect.
- R3: Further data bytes in the same write are each acknowledged and loaded. The wiper output changes only after the acknowledge clock of a data byte completes, never during its eight data bits.
- R4: After address+W and command 00h, a repeated Start with address+R is acknowledged and returns a byte with bit 7 = 0 and the wiper in bits 6:0. Address+R with no command 00h since the last Stop is not acknowledged.
- R5: When the controller acknowledges a returned byte, the same wiper byte is sent again. When it does not acknowledge, the target releases the data line and does not pull it again before the next Start.
- R6: A command code other than 00h is not acknowledged. Later bytes up to the next Start or Stop are not acknowledged and do not change the wiper.
- R7: After the general-call address, the second byte and every later byte up to the next Stop are not acknowledged and leave the wiper unchanged.
- R8: Reset and an asserted brown-out input force the wiper to 40h. While brown-out is asserted, no byte is acknowledged and the data line is released.
- R9: Pulses on either bus line shorter than FILT_NS are rejected: they create no clock edge, no Start and no Stop.
- R10: The data-line enable changes only while the bus clock is low, and at least HOLD_NS after its falling edge.
- R11: A Start or repeated Start at any bit position restarts address reception, and a partly received data byte is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| brownout_i | input | 1 | Brown-out flag; holds the wiper at mid-scale and mutes the bus side |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line as seen on the wire |
| sda_oe_o | output | 1 | When 1, the data line is pulled low |
| wiper_o | output | 7 | Current wiper setting |

## Verification
The assertions assume that the controller keeps each bus-clock phase longer than the filter delay plus the hold delay. Under that assumption, a drive change that the target launches always lands while the clock is still low. They also assume that the controller changes the data line only while the clock is low, except when it makes a Start or a Stop. The bench drives quarter-bit phases of 32 system cycles, and the filter and hold delays together take about 40 cycles. It injects pulses only of 8 cycles, well under the 13-cycle filter limit. Brown-out is applied only while the bus is idle.

// File: rtl/wpr_i2c_pkg.sv
package wpr_i2c_pkg;

  localparam int unsigned WIPER_W   = 7;
  localparam logic [6:0]  WIPER_MID = 7'h40;
  localparam logic [6:0]  ADDR_STD  = 7'b0101110;
  localparam logic [6:0]  ADDR_ALT  = 7'b0111110;
  localparam logic [7:0]  CMD_WIPER = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDAT,
    ST_GCB,
    ST_ACK,
    ST_RDAT,
    ST_MACK,
    ST_IGN
  } st_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/wpr_line_filter.sv
module wpr_line_filter #(
  parameter int unsigned FILT_CYC = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);

  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        cnt_q <= '0;
        out_q <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;

  generate
    if (FILT_CYC >= 2) begin : g_chk
      // R9
      stable_before_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(out_q) |-> ($past(sync_q[1], 1) == out_q && $past(sync_q[1], 2) == out_q));
    end
  endgenerate

endmodule

// File: rtl/wpr_bus_events.sv
module wpr_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/wpr_target_ctrl.sv
module wpr_target_ctrl
  import wpr_i2c_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 30,
  parameter logic [6:0]  DEV_ADDR = ADDR_STD
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               brownout_i,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  output logic               sda_oe_o,
  output logic [WIPER_W-1:0] wiper_o
);

  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  st_e              state_q, nxt_q;
  logic [3:0]       cnt_q;
  logic [7:0]       rx_q, tx_q;
  logic             cmd_ok_q, commit_q, mack_q;
  logic [6:0]       wdat_q, wiper_q;
  logic             oe_q, pend_q;
  logic [HW-1:0]    hold_q;
  logic             byte_end;

  assign byte_end = scl_fall_i && (cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      cmd_ok_q <= 1'b0;
      commit_q <= 1'b0;
      mack_q   <= 1'b0;
      wdat_q   <= '0;
      wiper_q  <= WIPER_MID;
      oe_q     <= 1'b0;
      pend_q   <= 1'b0;
      hold_q   <= '0;
    end else if (brownout_i) begin
      state_q  <= ST_IDLE;
      cmd_ok_q <= 1'b0;
      commit_q <= 1'b0;
      wiper_q  <= WIPER_MID;
      oe_q     <= 1'b0;
      pend_q   <= 1'b0;
      hold_q   <= '0;
    end else begin
      // delayed launch of the data-line enable
      if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
        if (hold_q == HW'(1)) oe_q <= pend_q;
      end
      if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        commit_q <= 1'b0;
        oe_q     <= 1'b0;
        pend_q   <= 1'b0;
        hold_q   <= '0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        cmd_ok_q <= 1'b0;
        commit_q <= 1'b0;
        oe_q     <= 1'b0;
        pend_q   <= 1'b0;
        hold_q   <= '0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_CMD, ST_WDAT, ST_GCB: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (byte_end) begin
              cnt_q   <= '0;
              state_q <= ST_IGN;
              if (state_q == ST_ADDR) begin
                if (rx_q[7:1] == DEV_ADDR && !rx_q[0]) begin
                  state_q <= ST_ACK; nxt_q <= ST_CMD;
                  pend_q  <= 1'b1;   hold_q <= HW'(HOLD_CYC);
                end else if (rx_q[7:1] == DEV_ADDR && cmd_ok_q) begin
                  state_q <= ST_ACK; nxt_q <= ST_RDAT;
                  pend_q  <= 1'b1;   hold_q <= HW'(HOLD_CYC);
                end else if (rx_q == 8'h00) begin
                  state_q <= ST_ACK; nxt_q <= ST_GCB;
                  pend_q  <= 1'b1;   hold_q <= HW'(HOLD_CYC);
                end
              end else if (state_q == ST_CMD) begin
                cmd_ok_q <= (rx_q == CMD_WIPER);
                if (rx_q == CMD_WIPER) begin
                  state_q <= ST_ACK; nxt_q <= ST_WDAT;
                  pend_q  <= 1'b1;   hold_q <= HW'(HOLD_CYC);
                end
              end else if (state_q == ST_WDAT) begin
                wdat_q   <= rx_q[6:0];
                commit_q <= 1'b1;
                state_q  <= ST_ACK; nxt_q <= ST_WDAT;
                pend_q   <= 1'b1;   hold_q <= HW'(HOLD_CYC);
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              if (commit_q) begin
                wiper_q  <= wdat_q;
                commit_q <= 1'b0;
              end
              state_q <= nxt_q;
              cnt_q   <= '0;
              hold_q  <= HW'(HOLD_CYC);
              if (nxt_q == ST_RDAT) begin
                tx_q   <= {1'b0, wiper_q};
                pend_q <= 1'b1;
              end else begin
                pend_q <= 1'b0;
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              hold_q <= HW'(HOLD_CYC);
              if (cnt_q == 4'd8) begin
                state_q <= ST_MACK;
                cnt_q   <= '0;
                pend_q  <= 1'b0;
              end else begin
                tx_q   <= {tx_q[6:0], 1'b0};
                pend_q <= ~tx_q[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                state_q <= ST_RDAT;
                cnt_q   <= '0;
                tx_q    <= {1'b0, wiper_q};
                pend_q  <= 1'b1;
                hold_q  <= HW'(HOLD_CYC);
              end else begin
                state_q <= ST_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign wiper_o  = wiper_q;

  // R8
  brownout_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brownout_i |=> !sda_oe_o);

  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(oe_q) && !$past(brownout_i)) |-> !scl_i);

  // R3
  wiper_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(wiper_q) && !$past(brownout_i)) |->
      $past(state_q == ST_ACK && scl_fall_i && commit_q));

  // R11
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);

endmodule

// File: rtl/wiper_reg_i2c_target.sv
module wiper_reg_i2c_target
  import wpr_i2c_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned FILT_NS  = 50,
  parameter int unsigned HOLD_NS  = 300,
  parameter bit          ALT_ADDR = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               brownout_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [WIPER_W-1:0] wiper_o
);

  localparam int unsigned CLK_MHZ  = CLK_HZ / 1_000_000;
  localparam int unsigned FILT_CYC = (ns_to_cyc(FILT_NS, CLK_MHZ) < 2) ? 2 : ns_to_cyc(FILT_NS, CLK_MHZ);
  localparam int unsigned HOLD_CYC = (ns_to_cyc(HOLD_NS, CLK_MHZ) < 1) ? 1 : ns_to_cyc(HOLD_NS, CLK_MHZ);
  localparam logic [6:0]  DEV_ADDR = ALT_ADDR ? ADDR_ALT : ADDR_STD;

  logic [1:0] raw_lines, flt_lines;
  logic       scl_rise, scl_fall, start_cond, stop_cond;

  assign raw_lines = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_filt
      wpr_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (raw_lines[g]),
        .line_o (flt_lines[g])
      );
    end
  endgenerate

  wpr_bus_events u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (flt_lines[1]),
    .sda_i      (flt_lines[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_cond),
    .stop_o     (stop_cond)
  );

  wpr_target_ctrl #(.HOLD_CYC(HOLD_CYC), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .brownout_i (brownout_i),
    .scl_i      (flt_lines[1]),
    .sda_i      (flt_lines[0]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_cond),
    .stop_i     (stop_cond),
    .sda_oe_o   (sda_oe_o),
    .wiper_o    (wiper_o)
  );

endmodule

// File: tb/wiper_reg_i2c_target_tb_top.sv
`timescale 1ns/1ps
module wiper_reg_i2c_target_tb_top;

  localparam int Q        = 32;
  localparam int HOLD_CYC = 25;   // 100 ns at 250 MHz
  localparam logic [6:0] A_OWN = 7'b0101110;
  localparam logic [6:0] A_ALT = 7'b0111110;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic brownout = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [6:0] wiper;
  logic sda_bus;

  int n_chk = 0;
  int n_err = 0;
  logic [6:0] model_w;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  wiper_reg_i2c_target #(.CLK_HZ(250_000_000), .FILT_NS(50), .HOLD_NS(100), .ALT_ADDR(1'b0)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .brownout_i (brownout),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .wiper_o    (wiper)
  );

  // hold-delay monitor (R10)
  logic scl_s = 1'b1;
  int   since_fall = 0;
  logic oe_prev = 1'b0;
  int   hold_viol = 0;
  int   drv_cnt = 0;
  always @(posedge clk) begin
    if (scl_s && !scl_m) since_fall <= 0;
    else since_fall <= since_fall + 1;
    scl_s <= scl_m;
  end
  always @(negedge clk) begin
    if (rst_ni && !brownout && sda_oe !== oe_prev) begin
      if (sda_oe) drv_cnt++;
      if (scl_s || since_fall < HOLD_CYC) hold_viol++;
    end
    oe_prev = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(2*Q); sda_m = 1'b0; wt(2*Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(2*Q); sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
  endtask

  // clock pulse with a short low glitch in its high phase
  task automatic bit_out_scl_glitch(input logic b);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0; wt(8); scl_m = 1'b1; wt(Q-8);
    scl_m = 1'b0; wt(Q);
  endtask

  // data high with a short low glitch while the clock is high
  task automatic bit_out_sda_glitch();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(8); sda_m = 1'b1; wt(Q-8);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_bus; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic byte_out(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(r);
    ack = ~r;
  endtask

  task automatic byte_in(input logic m_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_in(r);
      b[i] = r;
    end
    bit_out(~m_ack);
  endtask

  task automatic write_xfer(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d0,
                            input logic [7:0] d1, input int n,
                            output logic aa, output logic ca, output logic da);
    logic t;
    bus_start();
    byte_out({a, 1'b0}, aa);
    byte_out(c, ca);
    byte_out(d0, da);
    if (n > 1) begin
      byte_out(d1, t);
      da = da & t;
    end
    bus_stop();
  endtask

  function automatic logic [7:0] exp_read(input logic [6:0] w);
    return {1'b0, w};
  endfunction

  task automatic read_one(output logic [7:0] b, output logic allack);
    logic a0, a1, a2;
    bus_start();
    byte_out({A_OWN, 1'b0}, a0);
    byte_out(8'h00, a1);
    bus_start();
    byte_out({A_OWN, 1'b1}, a2);
    byte_in(1'b0, b);
    bus_stop();
    allack = a0 & a1 & a2;
  endtask

  initial begin : watchdog
    repeat (195_000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic aa, ca, da, t;
    logic [7:0] b0, b1;
    void'($urandom(32'h5EED));
    wt(5);
    // R8 reset state
    check("R8 reset wiper", int'(wiper), 'h40);
    check("R8 reset oe", int'(sda_oe), 0);
    rst_ni = 1'b1;
    wt(Q);
    model_w = 7'h40;

    // R2 single write
    write_xfer(A_OWN, 8'h00, 8'h15, 8'h00, 1, aa, ca, da);
    check("R2 acks", int'({aa, ca, da}), 7);
    check("R2 wiper", int'(wiper), 'h15);

    // R2 bit 7 ignored
    write_xfer(A_OWN, 8'h00, 8'h9A, 8'h00, 1, aa, ca, da);
    check("R2 bit7 dont-care", int'(wiper), 'h1A);

    // R3 word write and commit timing
    bus_start();
    byte_out({A_OWN, 1'b0}, aa);
    byte_out(8'h00, ca);
    for (int i = 7; i >= 0; i--) bit_out(logic'((8'h33 >> i) & 1));
    check("R3 no early commit", int'(wiper), 'h1A);
    bit_in(t);
    check("R3 data ack", int'(t), 0);
    check("R3 commit after ack", int'(wiper), 'h33);
    byte_out(8'hC4, da);
    bus_stop();
    check("R3 second byte ack", int'(da), 1);
    check("R3 second byte loaded", int'(wiper), 'h44);
    model_w = 7'h44;

    // R4 read
    read_one(b0, aa);
    check("R4 read acks", int'(aa), 1);
    check("R4 read data", int'(b0), int'(exp_read(model_w)));

    // R5 continued read then NACK release
    bus_start();
    byte_out({A_OWN, 1'b0}, aa);
    byte_out(8'h00, ca);
    bus_start();
    byte_out({A_OWN, 1'b1}, t);
    byte_in(1'b1, b0);
    byte_in(1'b0, b1);
    check("R5 first byte", int'(b0), int'(exp_read(model_w)));
    check("R5 repeated byte", int'(b1), int'(exp_read(model_w)));
    bit_in(t);
    check("R5 released after NACK", int'(t), 1);
    bus_stop();

    // R4 read without command code
    bus_start();
    byte_out({A_OWN, 1'b1}, aa);
    bus_stop();
    check("R4 read without command NACK", int'(aa), 0);

    // R1 foreign address
    write_xfer(A_ALT, 8'h00, 8'h11, 8'h00, 1, aa, ca, da);
    check("R1 foreign address NACK", int'({aa, ca, da}), 0);
    check("R1 wiper unchanged", int'(wiper), int'(model_w));

    // R6 bad command
    write_xfer(A_OWN, 8'h05, 8'h22, 8'h00, 1, aa, ca, da);
    check("R6 address ack", int'(aa), 1);
    check("R6 command NACK", int'({ca, da}), 0);
    check("R6 wiper unchanged", int'(wiper), int'(model_w));

    // R7 hardware general call
    bus_start();
    byte_out(8'h00, aa);
    byte_out(8'h07, ca);
    byte_out(8'h5A, da);
    bus_stop();
    check("R7 general call ack", int'(aa), 1);
    check("R7 later bytes NACK", int'({ca, da}), 0);
    check("R7 wiper unchanged", int'(wiper), int'(model_w));

    // R11 repeated start mid data byte
    bus_start();
    byte_out({A_OWN, 1'b0}, aa);
    byte_out(8'h00, ca);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_start();
    byte_out({A_OWN, 1'b0}, aa);
    byte_out(8'h00, ca);
    byte_out(8'h2B, da);
    bus_stop();
    check("R11 restart acks", int'({aa, ca, da}), 7);
    check("R11 partial byte discarded", int'(wiper), 'h2B);
    model_w = 7'h2B;

    // R9 clock glitch during a data bit
    bus_start();
    byte_out({A_OWN, 1'b0}, aa);
    byte_out(8'h00, ca);
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) bit_out_scl_glitch(logic'((8'h66 >> i) & 1));
      else bit_out(logic'((8'h66 >> i) & 1));
    end
    bit_in(t);
    bus_stop();
    check("R9 clock glitch rejected", int'(wiper), 'h66);

    // R9 data glitch while clock high
    bus_start();
    byte_out({A_OWN, 1'b0}, aa);
    byte_out(8'h00, ca);
    bit_out(1'b0);
    for (int i = 0; i < 7; i++) begin
      if (i == 3) bit_out_sda_glitch();
      else bit_out(1'b1);
    end
    bit_in(t);
    bus_stop();
    check("R9 data glitch rejected", int'(wiper), 'h7F);
    model_w = 7'h7F;

    // R8 brown-out
    brownout = 1'b1;
    wt(4);
    check("R8 brownout mid-scale", int'(wiper), 'h40);
    write_xfer(A_OWN, 8'h00, 8'h12, 8'h00, 1, aa, ca, da);
    check("R8 silent during brownout", int'({aa, ca, da}), 0);
    check("R8 held at mid-scale", int'(wiper), 'h40);
    brownout = 1'b0;
    wt(Q);
    write_xfer(A_OWN, 8'h00, 8'h12, 8'h00, 1, aa, ca, da);
    check("R8 operational after brownout", int'(wiper), 'h12);
    model_w = 7'h12;

    // random write/read pairs
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v0, v1;
      int nb;
      v0 = 8'($urandom);
      v1 = 8'($urandom);
      nb = int'($urandom_range(1, 2));
      write_xfer(A_OWN, 8'h00, v0, v1, nb, aa, ca, da);
      model_w = (nb > 1) ? v1[6:0] : v0[6:0];
      check("R3 random write acks", int'({aa, ca, da}), 7);
      read_one(b0, t);
      check("R4 random readback", int'(b0), int'(exp_read(model_w)));
    end

    // R10 hold delay over the whole run
    check("R10 hold violations", hold_viol, 0);
    check("R10 target drove the bus", int'(drv_cnt > 0), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule